// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Forced-Parity Check

This block recovers asynchronous serial characters from a single receive line. A free-running strobe at sixteen times the bit rate paces it. It synchronises the line and waits for a falling level. It confirms the start bit half a bit later, then samples every following bit at its centre. It assembles a character of five to eight bits and checks an optional parity slot and the stop bit. The character is delivered on a parallel bus together with its error flags.

The parity slot can be checked in two ways. In the normal way it is checked against the parity computed from the data bits. In the forced way the slot must hold the inverse of the even-select input. This lets a bus with one sender and many listeners mark some characters as addresses and the rest as data. A sticky error interrupt request is raised for characters that carry an error when the error interrupt is enabled. It stays raised until it is acknowledged.

Top module: `serial_rx_sticky`

## Requirements
- R1: While idle, the receiver starts a character only on a strobe where the synchronised line is low. It re-samples the line eight strobes later, and if the line is high then it drops back to idle without producing a character.
- R2: The number of data bits is 5 plus `cfg_len` (0 to 3 gives 5 to 8 bits). Bits are taken first-received into bit 0 of `rx_data`, and every bit above the configured length reads 0.
- R3: With `cfg_par_en`=1 and `cfg_sticky`=0, the bit after the data bits is a parity slot. `cfg_even_sel`=1 requires an even count of ones over the data and slot, and 0 requires an odd count. A mismatch sets `rx_par_err`.
- R4: With `cfg_par_en`=1 and `cfg_sticky`=1, the parity slot must equal the inverse of `cfg_even_sel`, whatever the data bits are. Any other value sets `rx_par_err`.
- R5: With `cfg_par_en`=0 there is no parity slot. `cfg_sticky` and `cfg_even_sel` then have no effect, and `rx_par_err` is 0.
- R6: The stop bit is the single bit that follows the data bits, or the parity slot when there is one. If it is sampled as 0, `rx_frm_err` is set.
- R7: Each character is presented on `rx_data`, `rx_par_err` and `rx_frm_err` together with a `rx_valid` pulse that lasts exactly one clock.
- R8: `irq_err` is set only by a character that has a parity or framing error while `irq_en` is 1. An error character with `irq_en`=0 and a clean character leave it at 0.
- R9: Once set, `irq_err` stays high until `irq_ack` is 1 on a clock edge, which clears it.
- R10: After reset, `rx_valid`, `rx_data`, both error flags and `irq_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling strobe, sixteen per bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code, bits = 5 + code |
| cfg_par_en | input | 1 | Parity slot present |
| cfg_even_sel | input | 1 | Even parity select (normal mode) or inverse of forced slot value (sticky mode) |
| cfg_sticky | input | 1 | Forced-parity mode |
| irq_en | input | 1 | Error interrupt enable |
| irq_ack | input | 1 | Clears the interrupt request |
| rx_valid | output | 1 | One-clock character strobe |
| rx_data | output | 8 | Received character, zero-filled |
| rx_par_err | output | 1 | Parity error for this character |
| rx_frm_err | output | 1 | Stop bit sampled low |
| irq_err | output | 1 | Sticky error interrupt request |

## Verification
The bench builds the block with its defaults: sixteen strobes per bit, an eight-bit data path and a two-stage synchroniser. It drives a strobe every fourth clock, so one bit lasts 64 clocks and several characters fit in a short run. With these defaults every length code from 5 to 8 bits can be reached. Both values of even-select can be reached in normal and forced parity, and each can be combined with data whose computed parity disagrees with the forced slot. This separates the two checking modes.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_parity_eval.sv
module rx_parity_eval #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          slot,
  input  logic          even_sel,
  input  logic          sticky,
  output logic          par_err
);
  logic odd_total;

  always_comb begin
    odd_total = (^data) ^ slot;
    if (sticky) par_err = (slot == even_sel);
    else        par_err = even_sel ? odd_total : ~odd_total;
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DW       = 8,
  parameter int MIN_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  input  logic [$clog2(DW-MIN_BITS+1)-1:0] cfg_len,
  input  logic                 cfg_par_en,
  input  logic                 cfg_even_sel,
  input  logic                 cfg_sticky,
  output logic                 rx_valid,
  output logic [DW-1:0]        rx_data,
  output logic                 rx_par_err,
  output logic                 rx_frm_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DW);
  localparam int LEN_W = $clog2(DW-MIN_BITS+1);
  localparam int HALF  = OVS / 2;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic [DW-1:0]     shreg;
  logic              slot_q;
  logic [LEN_W-1:0]  len_q;
  logic              par_en_q, even_q, sticky_q;
  logic              par_bad;
  logic              at_mid;

  assign last_idx = IDX_W'(MIN_BITS-1) + IDX_W'(len_q);
  assign at_mid   = (cnt == CNT_W'(OVS-1));

  rx_parity_eval #(.DW(DW)) u_par (
    .data     (shreg),
    .slot     (slot_q),
    .even_sel (even_q),
    .sticky   (sticky_q),
    .par_err  (par_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      slot_q     <= 1'b0;
      len_q      <= '0;
      par_en_q   <= 1'b0;
      even_q     <= 1'b0;
      sticky_q   <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!line) begin
              state    <= RX_START;
              cnt      <= '0;
              idx      <= '0;
              shreg    <= '0;
              len_q    <= cfg_len;
              par_en_q <= cfg_par_en;
              even_q   <= cfg_even_sel;
              sticky_q <= cfg_sticky;
            end
          end
          RX_START: begin
            if (cnt == CNT_W'(HALF-1)) begin
              cnt   <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_mid) begin
              cnt        <= '0;
              shreg[idx] <= line;
              if (idx == last_idx) begin
                idx   <= '0;
                state <= par_en_q ? RX_PAR : RX_STOP;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_mid) begin
              cnt    <= '0;
              slot_q <= line;
              state  <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_mid) begin
              cnt        <= '0;
              state      <= RX_IDLE;
              rx_valid   <= 1'b1;
              rx_data    <= shreg;
              rx_frm_err <= ~line;
              rx_par_err <= par_en_q & par_bad;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> (MIN_BITS + int'(len_q))) == '0)); // R2
  AST_NO_PAR_ERR_OFF: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !par_en_q) |-> !rx_par_err); // R5
  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && tick && line) |=> (state == RX_IDLE)); // R1
endmodule

// File: rtl/serial_rx_sticky.sv
module serial_rx_sticky #(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_even_sel,
  input  logic          cfg_sticky,
  input  logic          irq_en,
  input  logic          irq_ack,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_par_err,
  output logic          rx_frm_err,
  output logic          irq_err
);
  logic line_s;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  rx_frame_fsm #(.OVS(OVS), .DW(DW), .MIN_BITS(MIN_BITS)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick16),
    .line         (line_s),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_even_sel (cfg_even_sel),
    .cfg_sticky   (cfg_sticky),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_par_err   (rx_par_err),
    .rx_frm_err   (rx_frm_err)
  );

  always_ff @(posedge clk) begin
    if (rst)                                                irq_err <= 1'b0;
    else if (rx_valid && (rx_par_err || rx_frm_err) && irq_en) irq_err <= 1'b1;
    else if (irq_ack)                                       irq_err <= 1'b0;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_err && !irq_ack) |=> irq_err); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_err) |-> $past(rx_valid && (rx_par_err || rx_frm_err) && irq_en)); // R8
endmodule

// File: tb/serial_rx_sticky_tb.sv
`timescale 1ns/1ps
module serial_rx_sticky_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_even_sel = 1'b0, cfg_sticky = 1'b0;
  logic       irq_en = 1'b0, irq_ack = 1'b0;
  logic       rx_valid, rx_par_err, rx_frm_err, irq_err;
  logic [7:0] rx_data;

  int total = 0, bad = 0;
  int vcount = 0, wide = 0;
  logic [7:0] cap_d;
  logic cap_pe, cap_fe, prev_v = 1'b0;
  bit done = 0;
  int tdiv = 0;

  serial_rx_sticky u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_even_sel(cfg_even_sel),
    .cfg_sticky(cfg_sticky), .irq_en(irq_en), .irq_ack(irq_ack),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .irq_err(irq_err)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
    if (rx_valid) begin
      vcount <= vcount + 1;
      cap_d  <= rx_data;
      cap_pe <= rx_par_err;
      cap_fe <= rx_frm_err;
      if (prev_v) wide <= wide + 1;
    end
    prev_v <= rx_valid;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit calc_par(input logic [7:0] d, input bit even);
    bit odd = ^d;
    return even ? odd : ~odd;
  endfunction

  task automatic hold_bit(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit has_par,
                            input bit pbit, input bit stop_v);
    hold_bit(1'b0, 64);
    for (int i = 0; i < nb; i++) hold_bit(d[i], 64);
    if (has_par) hold_bit(pbit, 64);
    hold_bit(stop_v, 40);
    hold_bit(1'b1, 120);
  endtask

  task automatic run_char(input string req, input logic [7:0] d, input int nb,
                          input bit has_par, input bit pbit, input bit stop_v,
                          input bit epe, input bit efe);
    int v0 = vcount;
    logic [7:0] ed = d & 8'((1 << nb) - 1);
    send_frame(d, nb, has_par, pbit, stop_v);
    check(vcount == v0 + 1, req, "char count", vcount - v0, 1);
    check(cap_d == ed, req, "data", cap_d, ed);
    check(cap_pe == epe, req, "parity err", cap_pe, epe);
    check(cap_fe == efe, req, "framing err", cap_fe, efe);
  endtask

  task automatic t_reset();
    check(rx_valid == 0, "R10", "valid", rx_valid, 0);
    check(rx_data == 0, "R10", "data", rx_data, 0);
    check(rx_par_err == 0 && rx_frm_err == 0, "R10", "flags", {rx_par_err, rx_frm_err}, 0);
    check(irq_err == 0, "R10", "irq", irq_err, 0);
  endtask

  task automatic t_lengths();
    cfg_par_en = 0; cfg_sticky = 0;
    cfg_len = 2'd3; run_char("R2", 8'hA5, 8, 0, 0, 1, 0, 0);
    cfg_len = 2'd0; run_char("R2", 8'hF6, 5, 0, 0, 1, 0, 0);
    cfg_len = 2'd1; run_char("R2", 8'hFF, 6, 0, 0, 1, 0, 0);
    cfg_len = 2'd2; run_char("R2", 8'h2C, 7, 0, 0, 1, 0, 0);
    check(wide == 0, "R7", "valid wider than one clock", wide, 0);
  endtask

  task automatic t_normal_parity();
    cfg_par_en = 1; cfg_sticky = 0;
    cfg_len = 2'd2; cfg_even_sel = 1;
    run_char("R3", 8'h35, 7, 1, calc_par(8'h35, 1), 1, 0, 0);
    run_char("R3", 8'h35, 7, 1, ~calc_par(8'h35, 1), 1, 1, 0);
    cfg_len = 2'd1; cfg_even_sel = 0;
    run_char("R3", 8'h2A, 6, 1, calc_par(8'h2A, 0), 1, 0, 0);
    run_char("R3", 8'h2A, 6, 1, ~calc_par(8'h2A, 0), 1, 1, 0);
  endtask

  task automatic t_sticky();
    cfg_par_en = 1; cfg_sticky = 1; cfg_len = 2'd3;
    cfg_even_sel = 1;
    run_char("R4", 8'h01, 8, 1, 0, 1, 0, 0);
    run_char("R4", 8'h01, 8, 1, 1, 1, 1, 0);
    cfg_even_sel = 0;
    run_char("R4", 8'h01, 8, 1, 1, 1, 0, 0);
    run_char("R4", 8'h01, 8, 1, 0, 1, 1, 0);
  endtask

  task automatic t_no_parity();
    cfg_par_en = 0; cfg_sticky = 1; cfg_even_sel = 1; cfg_len = 2'd3;
    run_char("R5", 8'h5A, 8, 0, 0, 1, 0, 0);
    cfg_sticky = 0; cfg_even_sel = 0;
    run_char("R5", 8'h01, 8, 0, 0, 1, 0, 0);
  endtask

  task automatic t_framing();
    cfg_par_en = 0; cfg_sticky = 0; cfg_len = 2'd3;
    run_char("R6", 8'h3C, 8, 0, 0, 0, 0, 1);
    cfg_par_en = 1; cfg_even_sel = 1;
    run_char("R6", 8'h3C, 8, 1, calc_par(8'h3C, 1), 0, 0, 1);
  endtask

  task automatic t_glitch();
    int v0 = vcount;
    hold_bit(1'b0, 12);
    hold_bit(1'b1, 400);
    check(vcount == v0, "R1", "glitch produced char", vcount - v0, 0);
    cfg_par_en = 0; cfg_len = 2'd3;
    run_char("R1", 8'h96, 8, 0, 0, 1, 0, 0);
  endtask

  task automatic t_irq();
    cfg_par_en = 1; cfg_sticky = 1; cfg_even_sel = 0; cfg_len = 2'd3;
    irq_en = 0;
    run_char("R8", 8'h11, 8, 1, 0, 1, 1, 0);
    check(irq_err == 0, "R8", "irq while disabled", irq_err, 0);
    irq_en = 1;
    run_char("R8", 8'h11, 8, 1, 1, 1, 0, 0);
    check(irq_err == 0, "R8", "irq on clean char", irq_err, 0);
    run_char("R8", 8'h11, 8, 1, 0, 1, 1, 0);
    check(irq_err == 1, "R8", "irq on error char", irq_err, 1);
    irq_en = 0;
    repeat (100) @(negedge clk);
    check(irq_err == 1, "R9", "irq held", irq_err, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check(irq_err == 0, "R9", "irq after ack", irq_err, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    repeat (20) @(negedge clk);
    t_lengths();
    t_normal_parity();
    t_sticky();
    t_no_parity();
    t_framing();
    t_glitch();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule